// File: doc/BRIEF.md
# Branch and Skip Condition Unit

This unit decides where control flow goes next in a small 8-bit processor core. For each instruction it is handed, it works out three things: the program counter of the next instruction, whether the branch, jump or skip happens, and how many execution cycles the instruction costs. It takes the current program counter, a signed relative offset, a 16-bit pointer value for indirect jumps, the status byte, a 3-bit operation class, a bit index, a polarity, a tested data byte, two register operands, and a flag that says whether the instruction after the current one is two words long.

It handles six cases. A relative jump and an indirect jump are always taken. A branch can test one status bit selected by index. A branch can also test the signed relation N XOR V. A skip can test one bit of a data byte against a polarity. A skip can also compare two registers for equality. Fetch and pipeline control stay outside. The result is registered and shows up one cycle after the request strobe, and the outputs hold their value between requests.

Top module: `branch_skip_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `taken` are 0, and `next_pc` and `cycles` are 0.
- R2: A request presented with `in_valid` high produces its result on the outputs after the next rising clock edge, with `out_valid` high. In a cycle where `in_valid` is low, `out_valid` falls and `next_pc`, `taken` and `cycles` keep their previous values, whatever the other inputs do.
- R3: Operation class 0 is a relative jump. It is always taken, costs 2 cycles, and sets `next_pc` = `pc` + sign-extended 12-bit `offset` + 1, computed modulo 2^PC_W.
- R4: Operation class 1 is an indirect jump. It is always taken, costs 2 cycles, and sets `next_pc` = `zptr`.
- R5: Operation class 2 is a flag branch. It is taken when `sreg[bit_sel]` equals `polarity`. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7, so unsigned same-or-higher is bit 0 with polarity 0 and lower is bit 0 with polarity 1. When taken, it costs 2 cycles and sets `next_pc` = `pc` + sign-extended `offset[6:0]` + 1. Offset bits 11..7 have no effect.
- R6: A flag branch or signed branch that is not taken costs 1 cycle and sets `next_pc` = `pc` + 1.
- R7: Operation class 3 is a signed branch. It is taken when (`sreg[2]` XOR `sreg[3]`) equals `polarity`: polarity 0 gives greater-or-equal and polarity 1 gives less-than. `bit_sel` has no effect. The target and cycle cost are the same as in R5 and R6.
- R8: Operation class 4 is a bit skip. It skips when `test_byte[bit_sel]` equals `polarity`.
- R9: Operation class 5 is an equality skip. It skips when `reg_a` equals `reg_b`.
- R10: For a skip, `taken` shows whether the condition held. If it held, `next_pc` = `pc` + 2 with 2 cycles when `next_two_word` is 0, and `next_pc` = `pc` + 3 with 3 cycles when `next_two_word` is 1. If it failed, `next_pc` = `pc` + 1 with 1 cycle.
- R11: Operation classes 6 and 7 are not control flow. They give `taken` = 0, 1 cycle and `next_pc` = `pc` + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_class | input | 3 | Operation class (0..7) |
| pc | input | PC_W | Current program counter |
| offset | input | REL_W | Signed relative offset |
| zptr | input | PC_W | Pointer used as the indirect jump target |
| sreg | input | 8 | Status byte |
| bit_sel | input | 3 | Bit index for flag branches and bit skips |
| polarity | input | 1 | 1 tests for a set bit, 0 for a cleared bit |
| test_byte | input | DATA_W | Byte tested by a bit skip |
| reg_a | input | DATA_W | First operand of the equality skip |
| reg_b | input | DATA_W | Second operand of the equality skip |
| next_two_word | input | 1 | Instruction after this one is two words long |
| out_valid | output | 1 | Result strobe |
| next_pc | output | PC_W | Next program counter |
| taken | output | 1 | Branch or jump taken, or skip performed |
| cycles | output | 2 | Execution cycle count (1..3) |

## Verification
The only internal state is the result register. A fault there shows at the ports one cycle after the request. It appears as a wrong target, a wrong cycle count, or an output that changes during an idle cycle when it should hold. A wrong condition selection, such as a bit index pointing at the wrong flag, the signed relation built from the wrong bits, or a skip length that ignores the two-word flag, shows up the very next cycle as a `taken` value or cycle count that disagrees with the bench model. Random vectors cover most index and polarity combinations. Directed vectors cover offset sign boundaries, program counter wrap-around, and each signed relation.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   typedef enum logic [2:0] {
      OPC_RJMP   = 3'd0,
      OPC_IJMP   = 3'd1,
      OPC_BRFLAG = 3'd2,
      OPC_BRSIGN = 3'd3,
      OPC_SKBIT  = 3'd4,
      OPC_SKEQ   = 3'd5,
      OPC_NONE6  = 3'd6,
      OPC_NONE7  = 3'd7
   } bsu_op_e;

   localparam int STAT_W  = 8;
   localparam int FLAG_N  = 2;
   localparam int FLAG_V  = 3;
   localparam int CYC_W   = 2;

   function automatic logic is_skip(bsu_op_e op);
      return (op == OPC_SKBIT) || (op == OPC_SKEQ);
   endfunction

   function automatic logic is_branch(bsu_op_e op);
      return (op == OPC_BRFLAG) || (op == OPC_BRSIGN);
   endfunction

endpackage

// File: rtl/bsu_cond.sv
module bsu_cond
   import bsu_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int SEL_W = 3
) (
   input  bsu_op_e           op,
   input  logic [STAT_W-1:0] sreg,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic              polarity,
   input  logic [DATA_W-1:0] test_byte,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_b,
   output logic              cond
);

   logic [STAT_W-1:0] flag_hit;
   logic [STAT_W-1:0] data_hit;

   // per-bit match against the polarity for both the status byte and the data byte
   for (genvar i = 0; i < STAT_W; i++) begin : g_hit
      assign flag_hit[i] = ~(sreg[i] ^ polarity);
      assign data_hit[i] = ~(test_byte[i] ^ polarity);
   end

   logic sign_rel;
   assign sign_rel = sreg[FLAG_N] ^ sreg[FLAG_V];

   always_comb begin
      unique case (op)
         OPC_BRFLAG: cond = flag_hit[bit_sel];
         OPC_BRSIGN: cond = ~(sign_rel ^ polarity);
         OPC_SKBIT:  cond = data_hit[bit_sel];
         OPC_SKEQ:   cond = (reg_a == reg_b);
         OPC_RJMP,
         OPC_IJMP:   cond = 1'b1;
         default:    cond = 1'b0;
      endcase
   end

endmodule

// File: rtl/bsu_target.sv
module bsu_target
   import bsu_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int REL_W = 12,
   parameter int BR_W  = 7
) (
   input  bsu_op_e          op,
   input  logic [PC_W-1:0]  pc,
   input  logic [REL_W-1:0] offset,
   input  logic [PC_W-1:0]  zptr,
   input  logic             cond,
   input  logic             next_two_word,
   output logic [PC_W-1:0]  next_pc,
   output logic             taken,
   output logic [CYC_W-1:0] cycles
);

   logic [PC_W-1:0] ext_long;
   logic [PC_W-1:0] ext_short;

   if (PC_W > REL_W) begin : g_ext_long_pad
      assign ext_long = {{(PC_W-REL_W){offset[REL_W-1]}}, offset};
   end else begin : g_ext_long_flat
      assign ext_long = offset[PC_W-1:0];
   end

   if (PC_W > BR_W) begin : g_ext_short_pad
      assign ext_short = {{(PC_W-BR_W){offset[BR_W-1]}}, offset[BR_W-1:0]};
   end else begin : g_ext_short_flat
      assign ext_short = offset[PC_W-1:0];
   end

   logic [PC_W-1:0] pc_inc;
   logic [PC_W-1:0] skip_step;
   assign pc_inc    = pc + PC_W'(1);
   assign skip_step = next_two_word ? PC_W'(3) : PC_W'(2);

   always_comb begin
      next_pc = pc_inc;
      taken   = 1'b0;
      cycles  = CYC_W'(1);
      unique case (op)
         OPC_RJMP: begin
            next_pc = pc_inc + ext_long;
            taken   = 1'b1;
            cycles  = CYC_W'(2);
         end
         OPC_IJMP: begin
            next_pc = zptr;
            taken   = 1'b1;
            cycles  = CYC_W'(2);
         end
         OPC_BRFLAG, OPC_BRSIGN: begin
            if (cond) begin
               next_pc = pc_inc + ext_short;
               taken   = 1'b1;
               cycles  = CYC_W'(2);
            end
         end
         OPC_SKBIT, OPC_SKEQ: begin
            if (cond) begin
               next_pc = pc + skip_step;
               taken   = 1'b1;
               cycles  = next_two_word ? CYC_W'(3) : CYC_W'(2);
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
   import bsu_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int REL_W  = 12,
   parameter int BR_W   = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op_class,
   input  logic [PC_W-1:0]   pc,
   input  logic [REL_W-1:0]  offset,
   input  logic [PC_W-1:0]   zptr,
   input  logic [7:0]        sreg,
   input  logic [2:0]        bit_sel,
   input  logic              polarity,
   input  logic [DATA_W-1:0] test_byte,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_b,
   input  logic              next_two_word,
   output logic              out_valid,
   output logic [PC_W-1:0]   next_pc,
   output logic              taken,
   output logic [1:0]        cycles
);

   if (BR_W > REL_W) begin : g_bad_br_w
      $error("BR_W must not exceed REL_W");
   end
   if (REL_W > PC_W) begin : g_bad_rel_w
      $error("REL_W must not exceed PC_W");
   end
   if (DATA_W != STAT_W) begin : g_bad_data_w
      $error("DATA_W must equal the status width of 8");
   end

   bsu_op_e op;
   assign op = bsu_op_e'(op_class);

   logic cond;

   bsu_cond #(.DATA_W(DATA_W)) u_cond (
      .op        (op),
      .sreg      (sreg),
      .bit_sel   (bit_sel),
      .polarity  (polarity),
      .test_byte (test_byte),
      .reg_a     (reg_a),
      .reg_b     (reg_b),
      .cond      (cond)
   );

   logic [PC_W-1:0]  nx_pc;
   logic             nx_taken;
   logic [CYC_W-1:0] nx_cycles;

   bsu_target #(.PC_W(PC_W), .REL_W(REL_W), .BR_W(BR_W)) u_target (
      .op            (op),
      .pc            (pc),
      .offset        (offset),
      .zptr          (zptr),
      .cond          (cond),
      .next_two_word (next_two_word),
      .next_pc       (nx_pc),
      .taken         (nx_taken),
      .cycles        (nx_cycles)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         next_pc   <= '0;
         taken     <= 1'b0;
         cycles    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            next_pc <= nx_pc;
            taken   <= nx_taken;
            cycles  <= nx_cycles;
         end
      end
   end

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [2:0]      op_class,
   input logic [PC_W-1:0] pc,
   input logic [PC_W-1:0] zptr,
   input logic [7:0]      sreg,
   input logic            polarity,
   input logic            next_two_word,
   input logic            out_valid,
   input logic [PC_W-1:0] next_pc,
   input logic            taken,
   input logic [1:0]      cycles
);

   p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(next_pc) && $stable(taken) && $stable(cycles)));

   p_rjmp_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_class == 3'd0) |=> (taken && cycles == 2'd2));

   p_ijmp_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_class == 3'd1) |=> (taken && cycles == 2'd2 && next_pc == $past(zptr)));

   p_fallthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (taken || (cycles == 2'd1 && next_pc == $past(pc) + PC_W'(1))));

   p_signed_rel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_class == 3'd3) |=> (taken == ($past(sreg[2] ^ sreg[3]) == $past(polarity))));

   p_skip_cost_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_class == 3'd4 || op_class == 3'd5)) |=>
         (!taken || cycles == (2'd2 + {1'b0, $past(next_two_word)})));

   p_no_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_class[2:1] == 2'b11) |=> !taken);

endmodule

bind branch_skip_unit bsu_checker #(.PC_W(PC_W)) u_bsu_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .op_class      (op_class),
   .pc            (pc),
   .zptr          (zptr),
   .sreg          (sreg),
   .polarity      (polarity),
   .next_two_word (next_two_word),
   .out_valid     (out_valid),
   .next_pc       (next_pc),
   .taken         (taken),
   .cycles        (cycles)
);

// File: tb/branch_skip_unit_bench.sv
module branch_skip_unit_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_class = '0;
   logic [15:0] pc = '0;
   logic [11:0] offset = '0;
   logic [15:0] zptr = '0;
   logic [7:0]  sreg = '0;
   logic [2:0]  bit_sel = '0;
   logic        polarity = 1'b0;
   logic [7:0]  test_byte = '0;
   logic [7:0]  reg_a = '0;
   logic [7:0]  reg_b = '0;
   logic        next_two_word = 1'b0;
   logic        out_valid;
   logic [15:0] next_pc;
   logic        taken;
   logic [1:0]  cycles;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   branch_skip_unit u_branch_skip_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
      .pc(pc), .offset(offset), .zptr(zptr), .sreg(sreg), .bit_sel(bit_sel),
      .polarity(polarity), .test_byte(test_byte), .reg_a(reg_a), .reg_b(reg_b),
      .next_two_word(next_two_word), .out_valid(out_valid), .next_pc(next_pc),
      .taken(taken), .cycles(cycles)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(logic [2:0] op);
      case (op)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R7";
         3'd4: return "R8";
         3'd5: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic expect_of(output logic [15:0] e_pc, output logic e_tk, output logic [1:0] e_cy);
      logic c;
      e_pc = pc + 16'd1; e_tk = 1'b0; e_cy = 2'd1;
      case (op_class)
         3'd0: begin e_pc = pc + {{4{offset[11]}}, offset} + 16'd1; e_tk = 1'b1; e_cy = 2'd2; end
         3'd1: begin e_pc = zptr; e_tk = 1'b1; e_cy = 2'd2; end
         3'd2, 3'd3: begin
            c = (op_class == 3'd2) ? (sreg[bit_sel] == polarity) : ((sreg[2] ^ sreg[3]) == polarity);
            if (c) begin
               e_pc = pc + {{9{offset[6]}}, offset[6:0]} + 16'd1; e_tk = 1'b1; e_cy = 2'd2;
            end
         end
         3'd4, 3'd5: begin
            c = (op_class == 3'd4) ? (test_byte[bit_sel] == polarity) : (reg_a == reg_b);
            if (c) begin
               e_pc = pc + (next_two_word ? 16'd3 : 16'd2); e_tk = 1'b1;
               e_cy = next_two_word ? 2'd3 : 2'd2;
            end
         end
         default: ;
      endcase
   endtask

   // inputs already driven at a negedge; one posedge later, sample at the next negedge
   task automatic run_vec(string tag);
      logic [15:0] e_pc; logic e_tk; logic [1:0] e_cy;
      in_valid = 1'b1;
      expect_of(e_pc, e_tk, e_cy);
      @(negedge clk);
      check(tag, "out_valid", 32'(out_valid), 32'd1);
      check(tag, "next_pc", 32'(next_pc), 32'(e_pc));
      check(tag, "taken", 32'(taken), 32'(e_tk));
      check(tag, "cycles", 32'(cycles), 32'(e_cy));
   endtask

   task automatic set_vec(logic [2:0] op, logic [15:0] p, logic [11:0] off, logic [7:0] s,
                          logic [2:0] bs, logic pol);
      op_class = op; pc = p; offset = off; sreg = s; bit_sel = bs; polarity = pol;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [15:0] h_pc; logic h_tk; logic [1:0] h_cy;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "out_valid", 32'(out_valid), 32'd0);
      check("R1", "next_pc", 32'(next_pc), 32'd0);
      check("R1", "taken", 32'(taken), 32'd0);
      check("R1", "cycles", 32'(cycles), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 offset -1 lands on pc itself; R3 wrap at top of space
      set_vec(3'd0, 16'h1234, 12'hFFF, 8'h00, 3'd0, 1'b0); run_vec("R3");
      set_vec(3'd0, 16'hFFFF, 12'h7FF, 8'h00, 3'd0, 1'b0); run_vec("R3");
      set_vec(3'd0, 16'h0010, 12'h800, 8'h00, 3'd0, 1'b0); run_vec("R3");
      // R4 indirect
      zptr = 16'hBEEF;
      set_vec(3'd1, 16'h0100, 12'h000, 8'h00, 3'd0, 1'b0); run_vec("R4");
      // R5 most negative short offset, upper offset bits ignored
      set_vec(3'd2, 16'h0200, 12'hF40, 8'h01, 3'd0, 1'b1); run_vec("R5");
      set_vec(3'd2, 16'h0200, 12'h03F, 8'h80, 3'd7, 1'b1); run_vec("R5");
      // R5 unsigned same-or-higher: C clear, polarity 0
      set_vec(3'd2, 16'h0300, 12'h005, 8'hFE, 3'd0, 1'b0); run_vec("R5");
      // R6 not taken
      set_vec(3'd2, 16'h0300, 12'h005, 8'h01, 3'd0, 1'b0); run_vec("R6");
      // R7 signed: N=bit2, V=bit3, all four flag pairs, bit_sel varied
      for (int nv = 0; nv < 4; nv++) begin
         for (int pol = 0; pol < 2; pol++) begin
            set_vec(3'd3, 16'h0400, 12'h010, 8'(nv << 2), 3'(nv * 3), 1'(pol));
            run_vec("R7");
         end
      end
      // R8 / R10 bit skip with both word lengths
      test_byte = 8'h20;
      set_vec(3'd4, 16'h0500, 12'h000, 8'h00, 3'd5, 1'b1);
      next_two_word = 1'b0; run_vec("R8");
      next_two_word = 1'b1; run_vec("R10");
      set_vec(3'd4, 16'h0500, 12'h000, 8'h00, 3'd5, 1'b0); run_vec("R10");
      // R9 equality skip
      reg_a = 8'h5A; reg_b = 8'h5A;
      set_vec(3'd5, 16'hFFFE, 12'h000, 8'h00, 3'd0, 1'b0); run_vec("R9");
      reg_b = 8'h5B; run_vec("R9");
      next_two_word = 1'b0;
      // R11
      set_vec(3'd6, 16'h0600, 12'hFFF, 8'hFF, 3'd0, 1'b1); run_vec("R11");
      set_vec(3'd7, 16'h0600, 12'hFFF, 8'hFF, 3'd0, 1'b1); run_vec("R11");

      // R2 hold while idle: change every input, outputs must not move
      h_pc = next_pc; h_tk = taken; h_cy = cycles;
      in_valid = 1'b0;
      set_vec(3'd1, 16'h7777, 12'h123, 8'hAA, 3'd2, 1'b1); zptr = 16'h4321;
      @(negedge clk);
      check("R2", "out_valid idle", 32'(out_valid), 32'd0);
      check("R2", "next_pc held", 32'(next_pc), 32'(h_pc));
      check("R2", "taken held", 32'(taken), 32'(h_tk));
      check("R2", "cycles held", 32'(cycles), 32'(h_cy));

      // random mix
      for (int i = 0; i < 3000; i++) begin
         op_class = 3'($urandom_range(0, 7));
         pc = 16'($urandom); offset = 12'($urandom); zptr = 16'($urandom);
         sreg = 8'($urandom); bit_sel = 3'($urandom); polarity = 1'($urandom);
         test_byte = 8'($urandom); reg_a = 8'($urandom);
         reg_b = ($urandom_range(0, 3) == 0) ? reg_a : 8'($urandom);
         next_two_word = 1'($urandom);
         run_vec(tag_of(op_class));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule